// File: doc/BRIEF.md
# Receive FIFO with Fill-Driven Interrupt Policy

This block is an eight-entry byte queue that sits between a serial receive shift engine and the processor-side data register. The shift engine presents each received byte with a one-cycle valid strobe. Each processor read of the data register is a one-cycle read strobe. The queue returns its oldest entry on a registered data output. It reports its fill level continuously.

In the pass-through interrupt policy, the interrupt does not depend on a programmable threshold. It depends on the fill level and on reader activity. A single-cycle interrupt pulse is raised in these cases:
- a byte lands in an empty queue;
- a read leaves at least one byte behind;
- a byte arrives while the queue is full, in which case it replaces the newest entry;
- a read is attempted on an empty queue (an underflow), which also sets a sticky error flag.

A controller state machine with three states runs the policy: `ST_EMPTY`, `ST_PARTIAL` and `ST_FULL`. Its transitions are:
- FILL: `ST_EMPTY` to `ST_PARTIAL`, on an accepted write.
- TOP: `ST_PARTIAL` to `ST_FULL`, on a write without a read at level 7.
- DRAIN: `ST_FULL` to `ST_PARTIAL`, on a read without a write.
- LAST: `ST_PARTIAL` to `ST_EMPTY`, on a read without a write at level 1.
- Every other case keeps the current state.

Top module: `rxq_top`

## Requirements
- R1: With `q_enable` low, read and write strobes have no effect on level, data or the error flag. No interrupt pulse is produced unless both `q_enable` and `passthru_enable` are high.
- R2: The queue holds 8 entries. `fill_level` is 4 bits wide and runs from 0 (empty) to 8 (full).
- R3: A write into an empty queue raises `rx_irq` for exactly one cycle, the cycle after the strobe. A write into a queue holding 1 to 7 bytes raises no pulse.
- R4: A read that leaves the level nonzero raises `rx_irq` in the following cycle.
- R5: A read that leaves the queue empty raises no pulse.
- R6: A write at level 8 with no read replaces the most recently written entry. The level stays at 8, and a pulse is raised.
- R7: A read at level 0 is an underflow. It raises a pulse and sets `rx_err`, and it leaves `rd_data` unchanged.
- R8: Bytes are returned in arrival order. `rd_data` updates in the cycle after the read strobe.
- R9: A read and a write in the same cycle produce exactly one pulse. At level 0 this counts as an underflow and also stores the byte, giving level 1. At levels 1 to 8 the level is unchanged.
- R10: Synchronous reset gives level 0, no pulse, and a cleared error flag.
- R11: `rx_err` holds until `err_clear` is pulsed or reset is applied. An underflow in the same cycle as `err_clear` leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| q_enable | input | 1 | Queue enable |
| passthru_enable | input | 1 | Enables the fill-driven interrupt policy |
| wr_valid | input | 1 | Received byte strobe |
| wr_data | input | 8 | Received byte |
| rd_strobe | input | 1 | Data-register read strobe |
| err_clear | input | 1 | Clears the sticky error flag |
| rd_data | output | 8 | Oldest byte, registered |
| fill_level | output | 4 | Number of stored bytes |
| rx_irq | output | 1 | Single-cycle receive interrupt |
| rx_err | output | 1 | Sticky underflow flag |

## Verification
The bench fills the queue to 8 and writes once more. A design that dropped the new byte, or overwrote the oldest entry, would then return the wrong final byte on readout. The bench also drains to the last entry: a design that pulsed on the read that empties the queue would report a spurious interrupt. Underflow is driven alone, together with `err_clear`, and together with a write. These cases catch:
- a design that moved the pointers on an empty read;
- a design that let the clear win over a new underflow;
- a design that raised two pulses for the combined event.

The two enables are dropped one at a time, to expose interrupts that leak out, or strobes that are still honoured, while the queue is disabled.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
    typedef enum logic [1:0] {
        ST_EMPTY   = 2'd0,
        ST_PARTIAL = 2'd1,
        ST_FULL    = 2'd2
    } rxq_state_t;
endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
    parameter int DW    = 8,
    parameter int DEPTH = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic          pop,
    input  logic          overwrite,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout,
    output logic [LW-1:0] count
);
    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic [AW-1:0] wptr_nx, rptr_nx, newest;

    assign wptr_nx = (wptr == AW'(DEPTH - 1)) ? '0 : wptr + AW'(1);
    assign rptr_nx = (rptr == AW'(DEPTH - 1)) ? '0 : rptr + AW'(1);
    assign newest  = (wptr == '0) ? AW'(DEPTH - 1) : wptr - AW'(1);

    always_ff @(posedge clk) begin
        if (push)
            mem[wptr] <= din;
        else if (overwrite)
            mem[newest] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
            dout  <= '0;
        end else begin
            if (push)
                wptr <= wptr_nx;
            if (pop) begin
                rptr <= rptr_nx;
                dout <= mem[rptr];
            end
            if (push && !pop)
                count <= count + LW'(1);
            else if (pop && !push)
                count <= count - LW'(1);
        end
    end

    // R2: the level never exceeds the depth
    assert_level_bound_R2: assert property (@(posedge clk) disable iff (rst)
        count <= LW'(DEPTH));
    // R7: the controller never pops an empty store
    assert_no_pop_empty_R7: assert property (@(posedge clk) disable iff (rst)
        pop |-> (count != '0));
    // R6: a lone push never lands on a full store
    assert_no_push_full_R6: assert property (@(posedge clk) disable iff (rst)
        (push && !pop) |-> (count != LW'(DEPTH)));
endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
    import rxq_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          q_enable,
    input  logic          passthru_enable,
    input  logic          wr_valid,
    input  logic          rd_strobe,
    input  logic          err_clear,
    input  logic [LW-1:0] level,
    output logic          push,
    output logic          pop,
    output logic          overwrite,
    output logic          rx_irq,
    output logic          rx_err
);
    rxq_state_t state, state_nx;
    logic wr, rd, under, fire, policy_on;

    assign wr        = wr_valid && q_enable;
    assign rd        = rd_strobe && q_enable;
    assign policy_on = q_enable && passthru_enable;

    always_comb begin
        push      = 1'b0;
        pop       = 1'b0;
        overwrite = 1'b0;
        under     = 1'b0;
        fire      = 1'b0;
        state_nx  = state;
        unique case (state)
            ST_EMPTY: begin
                push  = wr;
                under = rd;
                fire  = wr || rd;
                if (wr) state_nx = ST_PARTIAL;           // FILL
            end
            ST_PARTIAL: begin
                push = wr;
                pop  = rd;
                fire = rd && (wr || level > LW'(1));
                if (wr && !rd && level == LW'(DEPTH - 1))
                    state_nx = ST_FULL;                  // TOP
                else if (rd && !wr && level == LW'(1))
                    state_nx = ST_EMPTY;                 // LAST
            end
            ST_FULL: begin
                pop       = rd;
                push      = wr && rd;
                overwrite = wr && !rd;
                fire      = wr || rd;
                if (rd && !wr) state_nx = ST_PARTIAL;    // DRAIN
            end
            default: state_nx = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_EMPTY;
        else     state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_irq <= 1'b0;
            rx_err <= 1'b0;
        end else begin
            rx_irq <= policy_on && fire;
            if (under)          rx_err <= 1'b1;
            else if (err_clear) rx_err <= 1'b0;
        end
    end

    // R2: the state agrees with the store's level
    assert_state_level_R2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_EMPTY) == (level == '0));
    // R3: a write into an empty queue pulses
    assert_first_irq_R3: assert property (@(posedge clk) disable iff (rst)
        (policy_on && wr_valid && level == '0) |=> rx_irq);
    // R5: a lone read of the last byte stays quiet
    assert_last_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        (q_enable && rd_strobe && !wr_valid && level == LW'(1)) |=> !rx_irq);
    // R7: underflow sets the error flag
    assert_underflow_err_R7: assert property (@(posedge clk) disable iff (rst)
        (q_enable && rd_strobe && level == '0) |=> rx_err);
    // R1: no pulse without both enables
    assert_irq_gate_R1: assert property (@(posedge clk) disable iff (rst)
        !(q_enable && passthru_enable) |=> !rx_irq);
    // R3: the pulse lasts a single cycle after a lone write
    assert_single_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        (rx_irq && !wr_valid && !rd_strobe) |=> !rx_irq);
endmodule

// File: rtl/rxq_top.sv
module rxq_top #(
    parameter int DW    = 8,
    parameter int DEPTH = 8,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          q_enable,
    input  logic          passthru_enable,
    input  logic          wr_valid,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_strobe,
    input  logic          err_clear,
    output logic [DW-1:0] rd_data,
    output logic [LW-1:0] fill_level,
    output logic          rx_irq,
    output logic          rx_err
);
    logic push, pop, overwrite;

    rxq_ctrl #(.DEPTH(DEPTH)) ctrl_i (
        .clk(clk), .rst(rst), .q_enable(q_enable),
        .passthru_enable(passthru_enable), .wr_valid(wr_valid),
        .rd_strobe(rd_strobe), .err_clear(err_clear), .level(fill_level),
        .push(push), .pop(pop), .overwrite(overwrite),
        .rx_irq(rx_irq), .rx_err(rx_err)
    );

    rxq_store #(.DW(DW), .DEPTH(DEPTH)) store_i (
        .clk(clk), .rst(rst), .push(push), .pop(pop),
        .overwrite(overwrite), .din(wr_data), .dout(rd_data),
        .count(fill_level)
    );

    // R8: data output is quiet when no read is accepted
    assert_dout_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !(q_enable && rd_strobe) |=> $stable(rd_data));
endmodule

// File: tb/rxq_top_tb_top.sv
`timescale 1ns/100ps
module rxq_top_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       q_en = 1'b0, pt_en = 1'b0;
    logic       wv = 1'b0, rs = 1'b0, ec = 1'b0;
    logic [7:0] wd = '0;
    logic [7:0] rdd;
    logic [3:0] lvl;
    logic       irq, err;
    int checks = 0, fails = 0;

    always #2.5 clk = ~clk;

    rxq_top dut_i (
        .clk(clk), .rst(rst), .q_enable(q_en), .passthru_enable(pt_en),
        .wr_valid(wv), .wr_data(wd), .rd_strobe(rs), .err_clear(ec),
        .rd_data(rdd), .fill_level(lvl), .rx_irq(irq), .rx_err(err)
    );

    initial begin
        #200000;
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input logic w, input logic [7:0] d, input logic r, input logic c);
        @(negedge clk);
        wv = w; wd = d; rs = r; ec = c;
        @(posedge clk);
        #1;
        wv = 0; rs = 0; ec = 0;
    endtask

    task automatic t_reset;
        chk("R10 level", lvl, 0);
        chk("R10 irq", irq, 0);
        chk("R10 err", err, 0);
    endtask

    task automatic t_basic;
        step(1, 8'h11, 0, 0); chk("R3 first irq", irq, 1); chk("R2 level1", lvl, 1);
        step(1, 8'h22, 0, 0); chk("R3 no irq nonempty", irq, 0); chk("R2 level2", lvl, 2);
        step(0, 0, 1, 0); chk("R4 irq", irq, 1); chk("R8 data", rdd, 8'h11);
        step(0, 0, 0, 0); chk("R3 pulse width", irq, 0);
        step(0, 0, 1, 0); chk("R5 quiet", irq, 0); chk("R8 data2", rdd, 8'h22);
        chk("R5 level", lvl, 0);
    endtask

    task automatic t_full;
        for (int i = 0; i < 8; i++) step(1, 8'hA0 + 8'(i), 0, 0);
        chk("R2 level full", lvl, 8);
        step(1, 8'hEE, 0, 0); chk("R6 irq", irq, 1); chk("R6 level", lvl, 8);
        step(1, 8'h77, 1, 0); chk("R9 full both irq", irq, 1); chk("R9 full level", lvl, 8);
        chk("R8 full first", rdd, 8'hA0);
        for (int i = 1; i < 7; i++) begin
            step(0, 0, 1, 0); chk("R8 order", rdd, 8'hA0 + 8'(i));
        end
        step(0, 0, 1, 0); chk("R6 newest replaced", rdd, 8'hEE); chk("R4 irq", irq, 1);
        step(0, 0, 1, 0); chk("R8 last", rdd, 8'h77); chk("R5 quiet", irq, 0);
    endtask

    task automatic t_under;
        step(0, 0, 1, 0); chk("R7 irq", irq, 1); chk("R7 err", err, 1);
        chk("R7 data held", rdd, 8'h77); chk("R7 level", lvl, 0);
        step(0, 0, 0, 0); step(0, 0, 0, 0); chk("R11 sticky", err, 1);
        step(0, 0, 0, 1); chk("R11 cleared", err, 0);
        step(0, 0, 1, 1); chk("R11 set wins", err, 1);
        step(0, 0, 0, 1); chk("R11 clear2", err, 0);
    endtask

    task automatic t_both_empty;
        step(1, 8'h5A, 1, 0); chk("R9 irq", irq, 1); chk("R9 err", err, 1);
        chk("R9 level", lvl, 1);
        step(0, 0, 0, 1); chk("R9 one pulse", irq, 0);
        step(1, 8'h5B, 0, 0);
        step(1, 8'h5C, 1, 0); chk("R9 mid irq", irq, 1); chk("R9 mid level", lvl, 2);
        chk("R9 mid data", rdd, 8'h5A);
        step(0, 0, 1, 0); step(0, 0, 1, 0); chk("R8 drain", rdd, 8'h5C);
    endtask

    task automatic t_gate;
        pt_en = 0;
        step(1, 8'h31, 0, 0); chk("R1 no irq pt off", irq, 0); chk("R1 level", lvl, 1);
        step(0, 0, 1, 0); chk("R1 no irq read", irq, 0); chk("R1 data", rdd, 8'h31);
        q_en = 0; pt_en = 1;
        step(1, 8'h32, 0, 0); chk("R1 write ignored", lvl, 0); chk("R1 irq off", irq, 0);
        step(0, 0, 1, 0); chk("R1 read ignored err", err, 0); chk("R1 read data", rdd, 8'h31);
        q_en = 1;
    endtask

    task automatic t_midreset;
        for (int i = 0; i < 3; i++) step(1, 8'h40, 0, 0);
        step(0, 0, 1, 0);
        @(negedge clk); rst = 1; @(posedge clk); #1; rst = 0;
        t_reset();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1; t_reset();
        @(negedge clk); rst = 0; q_en = 1; pt_en = 1;
        t_basic();
        t_full();
        t_under();
        t_both_empty();
        t_gate();
        t_midreset();
        repeat (2) @(posedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule